// File: doc/BRIEF.md
# Stereo Digital Volume Ramp and Mute Controller

This block sits in the per-frame sample path of a two-channel audio stream and scales each channel by a programmed attenuation. Attenuation is requested per channel as a 7-bit code in whole decibels. Internally the block tracks the level actually applied in eighth-decibel units. It multiplies every sample by a fractional coefficient, taken from a table computed at elaboration, that holds one entry per eighth-decibel step.

A 2-bit transition mode sets how the applied level reaches a new request. It can jump at once, jump at the next zero crossing of that channel, ramp by one eighth-decibel per frame, or ramp with each eighth step held back until a zero crossing. In the two zero-crossing modes a per-channel timer forces the pending move when no crossing arrives. A manual mute, an out-of-range code, and an optional silence detector all drive the target to the mute level, and they obey the same transition mode. A link input makes the second channel take its settings from the first.

Top module: `vol_ramp_ctrl`

## Requirements
- R1: An attenuation code c from 0 to 94 sets the target level to 8*c eighth-dB units. Code 0 gives a coefficient of exactly one, so samples pass through unchanged.
- R2: A code of 95 to 127, or a set manual mute bit, sets the target to the mute level 760, and every output sample produced at that level is 0.
- R3: In ramp_mode 2'b00 the level jumps to the target on the first frame strobe that sees the new request. Between strobes the level never changes.
- R4: In ramp_mode 2'b01 the level jumps to the target only on a strobe whose sample is zero or differs in sign bit from that channel's previous sample. Otherwise it holds. Each channel uses only its own samples.
- R5: In ramp_mode 2'b01 or 2'b11, the pending move is forced when no crossing arrives. Counting from the strobe that first sees the new target, or from the strobe that last took a step, the move happens on the ZC_TMO-th strobe after it.
- R6: In ramp_mode 2'b10 the level moves one eighth-dB unit toward the target on every strobe, in either direction, and stops at the target.
- R7: In ramp_mode 2'b11 the level moves one eighth-dB unit toward the target only on a strobe with a zero crossing (as in R4) or an expired timer (R5).
- R8: With chan_link high, the right channel uses atten_a and mute_a, and atten_b and mute_b have no effect.
- R9: With silence_mute_en high, a channel whose last AM_LEN samples were all 0 or all -1 has its target set to mute, starting at the next strobe. A single other sample clears its count, and the mute target is released from the following strobe on. The two channels are tracked independently.
- R10: both_muted is high only while both applied levels equal 760.
- R11: On each strobe the output is round(x*k/2^17), with x the input sample and k = round(2^17*10^(-L/160)). L is the level held before that strobe. Rounding adds 2^16 before the arithmetic shift, and the result is saturated to 24 bits.
- R12: After reset both levels are 0, both outputs are 0, and both_muted is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_stb | input | 1 | One-cycle strobe per stereo frame |
| smp_l | input | 24 | Signed left input sample |
| smp_r | input | 24 | Signed right input sample |
| atten_a | input | 7 | Left attenuation code, 1 dB units |
| atten_b | input | 7 | Right attenuation code, 1 dB units |
| mute_a | input | 1 | Left manual mute |
| mute_b | input | 1 | Right manual mute |
| ramp_mode | input | 2 | Transition mode: 00 jump, 01 jump at crossing, 10 ramp, 11 ramp at crossings |
| chan_link | input | 1 | Right channel follows left settings |
| silence_mute_en | input | 1 | Enables mute on long silence |
| out_l | output | 24 | Signed attenuated left sample |
| out_r | output | 24 | Signed attenuated right sample |
| gain_l | output | 10 | Left applied attenuation, 1/8 dB units |
| gain_r | output | 10 | Right applied attenuation, 1/8 dB units |
| both_muted | output | 1 | Both channels at the mute level |

## Verification
The bench builds the block with ZC_TMO set to 16 and AM_LEN set to 32, and keeps the data widths at their defaults. At these sizes the forced move after a missing zero crossing is reached in a few dozen frames, where the default would take hundreds. The silence detector can be engaged, released and re-armed at its exact boundary counts. The full eighth-decibel coefficient table stays at its default size, so the expected samples are computed against the real table.

// File: rtl/vr_pkg.sv
// Shared constants and the coefficient function for the volume ramp controller.
// Assumes levels are in 1/8 dB units and that the mute level sits one
// whole-dB step past the largest usable code.
package vr_pkg;
    localparam int CODE_W    = 7;
    localparam int FRAC_BITS = 3;
    localparam int MAX_CODE  = 94;
    localparam int MUTE_LVL  = (MAX_CODE + 1) << FRAC_BITS;
    localparam int LVL_W     = $clog2(MUTE_LVL + 1);
    localparam int DB20_LVL  = 20 << FRAC_BITS;

    // Elaboration-time coefficient for a level, unity scaled to 2^(cw-1).
    function automatic int unsigned coef_of(input int lvl, input int cw);
        real g;
        if (lvl >= MUTE_LVL) return 0;
        g = (2.0 ** (cw - 1)) * (10.0 ** (-real'(lvl) / real'(DB20_LVL)));
        return $rtoi(g + 0.5);
    endfunction
endpackage

// File: rtl/vr_silence.sv
// Per-channel silence detector: counts consecutive samples that are all
// zeros or all ones and flags a mute request once AM_LEN are seen.
// Assumes tick is a one-cycle frame strobe.
module vr_silence #(
    parameter int DW     = 24,
    parameter int AM_LEN = 8192
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic signed [DW-1:0] smp,
    input  logic                 en,
    output logic                 engaged
);
    localparam int CW = $clog2(AM_LEN + 1);

    logic [CW-1:0] cnt;
    logic          quiet;

    // Sample is digital silence when every bit is equal.
    assign quiet   = (smp == '0) || (smp == '1);
    assign engaged = en && (cnt == CW'(AM_LEN));

    // Saturating run-length counter of silent samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick) begin
            if (!quiet)                 cnt <= '0;
            else if (cnt != CW'(AM_LEN)) cnt <= cnt + 1'b1;
        end
    end

    AST_SILENCE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !quiet) |=> !engaged); // R9
endmodule

// File: rtl/vr_level.sv
// Per-channel level sequencer: derives the target level from code and mute,
// then moves the applied level per the transition mode, with zero-crossing
// gating and a forcing timer. Assumes tick is a one-cycle frame strobe.
module vr_level
    import vr_pkg::*;
#(
    parameter int DW  = 24,
    parameter int TMO = 768
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic signed [DW-1:0] smp,
    input  logic [CODE_W-1:0]    code,
    input  logic                 mute_req,
    input  logic [1:0]           xmode,
    output logic [LVL_W-1:0]     lvl
);
    localparam int TW = $clog2(TMO + 1);
    localparam logic [LVL_W-1:0] MUTE_L = LVL_W'(MUTE_LVL);
    localparam logic [LVL_W-1:0] ONE    = LVL_W'(1);

    logic [LVL_W-1:0] tgt, tgt_q, nxt;
    logic [TW-1:0]    tcnt;
    logic             prev_msb, zc, chg, expd, go;

    // Target level from request; out-of-range codes fold into mute.
    assign tgt  = (mute_req || code > CODE_W'(MAX_CODE)) ? MUTE_L
                                                        : LVL_W'({code, {FRAC_BITS{1'b0}}});
    assign zc   = (smp == '0) || (smp[DW-1] != prev_msb);
    assign chg  = (tgt != tgt_q);
    assign expd = !chg && (tcnt == TW'(TMO - 1));
    assign go   = xmode[0] ? (zc || expd) : 1'b1;

    // Next applied level: jump or single step, when allowed.
    always_comb begin
        nxt = lvl;
        if (lvl != tgt && go) begin
            if (!xmode[1])     nxt = tgt;
            else if (lvl < tgt) nxt = lvl + ONE;
            else               nxt = lvl - ONE;
        end
    end

    // Frame-rate state: level, last target, last sign, crossing timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl      <= '0;
            tgt_q    <= '0;
            prev_msb <= 1'b0;
            tcnt     <= '0;
        end else if (tick) begin
            lvl      <= nxt;
            tgt_q    <= tgt;
            prev_msb <= smp[DW-1];
            if (chg || lvl == tgt || go) tcnt <= '0;
            else                         tcnt <= tcnt + 1'b1;
        end
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(lvl)); // R3
    AST_ZC_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && xmode == 2'b01 && !zc && !expd && lvl != tgt) |=> $stable(lvl)); // R4
    AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tcnt < TW'(TMO)); // R5
    AST_RAMP_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && xmode[1]) |=> (lvl == $past(lvl) || lvl == $past(lvl) + ONE
                                || lvl == $past(lvl) - ONE)); // R6
    AST_LVL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        lvl <= MUTE_L); // R2
endmodule

// File: rtl/vr_gain.sv
// Applies a level to one sample: coefficient lookup from a table computed at
// elaboration, signed multiply, round-half-up and saturation to DW bits.
// Assumes lvl never exceeds the mute level.
module vr_gain
    import vr_pkg::*;
#(
    parameter int DW = 24,
    parameter int CW = 18
) (
    input  logic [LVL_W-1:0]     lvl,
    input  logic signed [DW-1:0] din,
    output logic signed [DW-1:0] dout
);
    localparam int PW = DW + CW + 1;

    logic [CW-1:0]        rom [MUTE_LVL + 1];
    logic [CW-1:0]        coef;
    logic signed [PW-1:0] prod, rnd, sh;
    logic [PW-DW:0]       hi;

    // One constant table entry per 1/8 dB level.
    for (genvar g = 0; g <= MUTE_LVL; g++) begin : g_rom
        localparam logic [CW-1:0] K = CW'(coef_of(g, CW));
        assign rom[g] = K;
    end

    assign coef = rom[lvl];

    // Scale, round half up, then clamp to the sample range.
    always_comb begin
        prod = PW'(din) * $signed({1'b0, coef});
        rnd  = prod + PW'(1 << (CW - 2));
        sh   = rnd >>> (CW - 1);
        hi   = sh[PW-1:DW-1];
        if (&hi || ~|hi)  dout = sh[DW-1:0];
        else if (sh[PW-1]) dout = {1'b1, {(DW-1){1'b0}}};
        else               dout = {1'b0, {(DW-1){1'b1}}};
    end
endmodule

// File: rtl/vol_ramp_ctrl.sv
// Two-channel volume ramp and mute controller. Per channel: silence
// detector, level sequencer, gain stage and an output register loaded on
// each frame strobe. Assumes frame_stb is one cycle wide per frame.
module vol_ramp_ctrl
    import vr_pkg::*;
#(
    parameter int DW     = 24,
    parameter int CW     = 18,
    parameter int AM_LEN = 8192,
    parameter int ZC_TMO = 768
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_stb,
    input  logic signed [DW-1:0] smp_l,
    input  logic signed [DW-1:0] smp_r,
    input  logic [CODE_W-1:0]    atten_a,
    input  logic [CODE_W-1:0]    atten_b,
    input  logic                 mute_a,
    input  logic                 mute_b,
    input  logic [1:0]           ramp_mode,
    input  logic                 chan_link,
    input  logic                 silence_mute_en,
    output logic signed [DW-1:0] out_l,
    output logic signed [DW-1:0] out_r,
    output logic [LVL_W-1:0]     gain_l,
    output logic [LVL_W-1:0]     gain_r,
    output logic                 both_muted
);
    localparam int NCH = 2;

    logic signed [DW-1:0] smp  [NCH];
    logic signed [DW-1:0] dout [NCH];
    logic signed [DW-1:0] oq   [NCH];
    logic [CODE_W-1:0]    code [NCH];
    logic [LVL_W-1:0]     lvl  [NCH];
    logic                 mreq [NCH];
    logic                 sil  [NCH];

    // Channel settings; link makes the right channel follow the left.
    assign smp[0]  = smp_l;
    assign smp[1]  = smp_r;
    assign code[0] = atten_a;
    assign code[1] = chan_link ? atten_a : atten_b;
    assign mreq[0] = mute_a || sil[0];
    assign mreq[1] = (chan_link ? mute_a : mute_b) || sil[1];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        vr_silence #(.DW(DW), .AM_LEN(AM_LEN)) u_sil (
            .clk(clk), .rst_n(rst_n), .tick(frame_stb), .smp(smp[c]),
            .en(silence_mute_en), .engaged(sil[c]));

        vr_level #(.DW(DW), .TMO(ZC_TMO)) u_lvl (
            .clk(clk), .rst_n(rst_n), .tick(frame_stb), .smp(smp[c]),
            .code(code[c]), .mute_req(mreq[c]), .xmode(ramp_mode), .lvl(lvl[c]));

        vr_gain #(.DW(DW), .CW(CW)) u_gain (
            .lvl(lvl[c]), .din(smp[c]), .dout(dout[c]));

        // Output sample register, loaded once per frame.
        always_ff @(posedge clk) begin
            if (!rst_n)         oq[c] <= '0;
            else if (frame_stb) oq[c] <= dout[c];
        end
    end

    assign out_l      = oq[0];
    assign out_r      = oq[1];
    assign gain_l     = lvl[0];
    assign gain_r     = lvl[1];
    assign both_muted = (lvl[0] == LVL_W'(MUTE_LVL)) && (lvl[1] == LVL_W'(MUTE_LVL));

    AST_MUTE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && lvl[0] == LVL_W'(MUTE_LVL)) |=> (out_l == '0)); // R2
    AST_LINK_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && chan_link && ramp_mode == 2'b00 && !silence_mute_en)
        |=> (gain_r == gain_l)); // R8
endmodule

// File: tb/vol_ramp_ctrl_bench.sv
// Directed bench for the volume ramp controller.
module vol_ramp_ctrl_bench;
    import vr_pkg::*;

    localparam int DW  = 24;
    localparam int CW  = 18;
    localparam int AML = 32;
    localparam int TMO = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_stb = 1'b0;
    logic signed [DW-1:0] smp_l = '0, smp_r = '0;
    logic [CODE_W-1:0] atten_a = '0, atten_b = '0;
    logic mute_a = 1'b0, mute_b = 1'b0, chan_link = 1'b0, silence_mute_en = 1'b0;
    logic [1:0] ramp_mode = 2'b00;
    logic signed [DW-1:0] out_l, out_r;
    logic [LVL_W-1:0] gain_l, gain_r;
    logic both_muted;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    vol_ramp_ctrl #(.DW(DW), .CW(CW), .AM_LEN(AML), .ZC_TMO(TMO)) u_vol_ramp_ctrl (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .smp_l(smp_l), .smp_r(smp_r),
        .atten_a(atten_a), .atten_b(atten_b), .mute_a(mute_a), .mute_b(mute_b),
        .ramp_mode(ramp_mode), .chan_link(chan_link), .silence_mute_en(silence_mute_en),
        .out_l(out_l), .out_r(out_r), .gain_l(gain_l), .gain_r(gain_r),
        .both_muted(both_muted));

    task automatic chk(input string req, input longint act, input longint expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Expected output from the stated formula.
    function automatic longint exp_out(input longint x, input int lvl);
        longint k, p;
        if (lvl >= 760) k = 0;
        else k = longint'($rtoi(131072.0 * (10.0 ** (-real'(lvl) / 160.0)) + 0.5));
        p = (x * k + 65536) >>> 17;
        if (p > 8388607) p = 8388607;
        if (p < -8388608) p = -8388608;
        return p;
    endfunction

    task automatic frame(input int l, input int r);
        @(negedge clk);
        smp_l = DW'(l);
        smp_r = DW'(r);
        frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
    endtask

    task automatic t_reset;
        chk("R12 gain_l", gain_l, 0);
        chk("R12 gain_r", gain_r, 0);
        chk("R12 out_l", out_l, 0);
        chk("R12 both_muted", both_muted, 0);
    endtask

    task automatic t_unity;
        frame(123456, -7654321);
        chk("R1 unity out_l", out_l, 123456);
        chk("R1 unity out_r", out_r, -7654321);
    endtask

    task automatic t_immediate;
        atten_a = 7'd10; atten_b = 7'd3;
        frame(1000000, -1000000);
        chk("R3 jump gain_l", gain_l, 80);
        chk("R3 jump gain_r", gain_r, 24);
        chk("R11 old level used", out_l, 1000000);
        frame(1000000, -8388608);
        chk("R11 out_l at 80", out_l, exp_out(1000000, 80));
        chk("R11 out_r at 24", out_r, exp_out(-8388608, 24));
    endtask

    task automatic t_mute;
        atten_a = 7'd100;
        frame(500, 500);
        chk("R2 code 100 level", gain_l, 760);
        chk("R10 one side muted", both_muted, 0);
        frame(500, 500);
        chk("R2 muted output", out_l, 0);
        atten_a = 7'd5; mute_a = 1'b1;
        frame(500, 500);
        chk("R2 manual mute level", gain_l, 760);
        mute_b = 1'b1;
        frame(500, 500);
        chk("R10 both muted", both_muted, 1);
        mute_a = 1'b0; mute_b = 1'b0; atten_a = 7'd0; atten_b = 7'd0;
        frame(500, 500);
        chk("R10 unmuted", both_muted, 0);
    endtask

    task automatic t_zc;
        ramp_mode = 2'b01;
        frame(5000, 5000);
        atten_a = 7'd20;
        frame(6000, 6000);
        chk("R4 no crossing hold", gain_l, 0);
        frame(-6000, 6000);
        chk("R4 sign change", gain_l, 160);
        atten_a = 7'd30;
        frame(-3000, 6000);
        chk("R4 same sign hold", gain_l, 160);
        frame(0, 6000);
        chk("R4 zero sample", gain_l, 240);
    endtask

    task automatic t_timeout;
        atten_a = 7'd40; atten_b = 7'd8;
        frame(1000, -1000);
        chk("R4 right crosses alone", gain_r, 64);
        chk("R5 left waits", gain_l, 240);
        for (int i = 1; i < TMO; i++) frame(1000, -1000);
        chk("R5 held before timeout", gain_l, 240);
        frame(1000, -1000);
        chk("R5 forced at timeout", gain_l, 320);
    endtask

    task automatic t_soft;
        ramp_mode = 2'b10;
        atten_a = 7'd38;
        frame(1000, 1000);
        chk("R6 first step down", gain_l, 319);
        for (int i = 0; i < 15; i++) frame(1000, 1000);
        chk("R6 reached target", gain_l, 304);
        frame(1000, 1000);
        chk("R6 stops at target", gain_l, 304);
        atten_a = 7'd39;
        for (int i = 0; i < 3; i++) frame(1000, 1000);
        chk("R6 ramp up", gain_l, 307);
        for (int i = 0; i < 5; i++) frame(1000, 1000);
        chk("R6 ramp up end", gain_l, 312);
    endtask

    task automatic t_softzc;
        ramp_mode = 2'b11;
        atten_a = 7'd37;
        frame(2000, 1000);
        chk("R7 no crossing", gain_l, 312);
        frame(-2000, 1000);
        chk("R7 step at crossing", gain_l, 311);
        frame(-2000, 1000);
        chk("R7 hold again", gain_l, 311);
        frame(0, 1000);
        chk("R7 step at zero", gain_l, 310);
    endtask

    task automatic t_link;
        ramp_mode = 2'b00;
        atten_a = 7'd12; atten_b = 7'd50; mute_b = 1'b1; chan_link = 1'b1;
        frame(1000, 1000);
        chk("R8 right follows left", gain_r, 96);
        chk("R8 b mute ignored", both_muted, 0);
        chan_link = 1'b0;
        frame(1000, 1000);
        chk("R8 unlinked uses b", gain_r, 760);
        mute_b = 1'b0; atten_a = 7'd0; atten_b = 7'd0;
        frame(1000, 1000);
    endtask

    task automatic t_auto;
        for (int i = 0; i <= AML; i++) frame((i % 2 == 0) ? 0 : -1, 777);
        chk("R9 disabled no mute", gain_l, 0);
        silence_mute_en = 1'b1;
        frame(0, 777);
        chk("R9 engaged", gain_l, 760);
        chk("R9 other channel free", gain_r, 0);
        chk("R10 single channel", both_muted, 0);
        frame(5, 777);
        chk("R9 muted sample output", out_l, 0);
        frame(0, 777);
        chk("R9 released", gain_l, 0);
        for (int i = 1; i < AML; i++) frame(-1, 777);
        chk("R9 one short of run", gain_l, 0);
        frame(0, 777);
        chk("R9 full run", gain_l, 760);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_unity;
        t_immediate;
        t_mute;
        t_zc;
        t_timeout;
        t_soft;
        t_softzc;
        t_link;
        t_auto;
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule